// File: doc/BRIEF.md
# Addressed Cell Demultiplexer Write Port

This block is the ingress half of a one-to-four cell demultiplexer. A sender presents words together with an active-low write strobe and a start-of-cell flag. On the first word of each cell, a two-bit channel select names one of four FIFOs, and every later word of that cell goes to the same FIFO. Each FIFO holds 128 entries of 9 bits. A combinational space flag tells the sender whether the FIFO currently named by the channel select has room for a complete cell. The cell length used for that decision sits in a programmable register and resets to 53 entries.

A strap input sets the bus width. In wide mode, each strobed write carries two 9-bit entries, which are stored low half first. In narrow mode, each write carries one 9-bit entry. The top seven data lines then become a load port for the cell-length register, which is written when a load strobe is high. Writes that would not fit in the target FIFO are dropped whole, and a sticky per-channel overflow bit records the loss. Each FIFO has a simple read port so that it can be drained: a pop strobe, a show-ahead head word and an empty flag.

A small state machine tracks cell framing. It has two states. S_IDLE is entered at reset, and while in S_IDLE no channel has been chosen yet. S_CELL means a cell is open on the latched channel. There are three transitions. T_START moves from S_IDLE to S_CELL on a strobed start-of-cell word. T_RESTART stays in S_CELL on a strobed start-of-cell word and latches a new channel. T_HOLD keeps the current state and channel on any other cycle.

Top module: `cell_demux_wr`

## Requirements
- R1: After reset, all four FIFOs are empty (`fifo_empty` = 4'b1111), `ovf` = 0, and `space_ok` is 1 for every channel select.
- R2: A word is written only on a rising clock edge where `wr_n` is 0. Each entry needs its own strobe, and with `wr_n` = 1 nothing is stored.
- R3: In narrow mode (`bus_narrow` = 1), each write stores exactly one entry, `din[8:0]`.
- R4: In wide mode (`bus_narrow` = 0), each write stores two entries: `din[8:0]` first, then `din[17:9]`.
- R5: The target channel is taken from `chan_sel` on a strobed word with `soc` = 1. Later words without `soc` go to that latched channel, whatever `chan_sel` is.
- R6: Strobed words that arrive after reset but before the first start-of-cell word are discarded. Once a cell has opened, the block stays in the open-cell state until reset.
- R7: `space_ok` is 1 exactly when the free entries in the FIFO named by `chan_sel` are at least the cell-length register value.
- R8: The cell-length register resets to 53. It is loaded from `din[17:11]` when `cfg_ld` = 1 and `bus_narrow` = 1. A `cfg_ld` pulse in wide mode leaves it unchanged.
- R9: A write that needs more entries than are free in its FIFO stores nothing; a wide write needs 2 free entries and a narrow write needs 1. The write also sets that channel's `ovf` bit, which stays set until reset.
- R10: `rd_data[9*i +: 9]` shows the oldest entry of FIFO i. `rd_en[i]` = 1 pops that entry when the FIFO is not empty. `fifo_empty[i]` is 1 when FIFO i holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write and read clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| soc | input | 1 | Start-of-cell flag for the word on `din` |
| chan_sel | input | 2 | Channel select, latched on start-of-cell and used for `space_ok` |
| bus_narrow | input | 1 | Bus-width strap: 1 = 9-bit data plus config port, 0 = 18-bit data |
| din | input | 18 | Input data; in narrow mode bits 17:11 form the config load port |
| cfg_ld | input | 1 | Load strobe for the cell-length register (narrow mode only) |
| space_ok | output | 1 | The selected FIFO can take a full cell |
| rd_en | input | 4 | Per-channel pop strobe |
| rd_data | output | 36 | Per-channel head entry, 9 bits per channel |
| fifo_empty | output | 4 | Per-channel empty flag |
| ovf | output | 4 | Per-channel sticky overflow flag |

## Verification
The assertions assume that `bus_narrow` is steady while a cell is being written. They also assume that inputs change only away from the rising edge, and that `rd_en` is not raised on an empty FIFO when an exact count step is expected. The stimulus changes every input at the falling edge and sets the strap before each word. It pops only channels that the bench model holds as non-empty. A per-channel queue model supplies all expected values: it applies the same framing, ordering and drop rules, and its results are compared when the FIFOs are drained.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_CELL = 1'b1
    } cdm_state_e;
endpackage

// File: rtl/cdm_fifo.sv
module cdm_fifo #(
    parameter int DEPTH = 128,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          pair,
    input  logic [W-1:0]  d_lo,
    input  logic [W-1:0]  d_hi,
    input  logic          rd,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] free_n, need;
    logic          fits, acc, rd_ok;

    always_comb begin
        free_n = CW'(DEPTH) - cnt;
        need   = pair ? CW'(2) : CW'(1);
        fits   = free_n >= need;
        acc    = wr && fits;
        drop   = wr && !fits;
        rd_ok  = rd && (cnt != '0);
        head   = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            mem[wp] <= d_lo;
            if (pair) mem[wp + AW'(1)] <= d_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (acc)   wp <= wp + AW'(need);
            if (rd_ok) rp <= rp + AW'(1);
            cnt <= cnt + (acc ? need : CW'(0)) - (rd_ok ? CW'(1) : CW'(0));
        end
    end

    // R9: occupancy never exceeds the storage
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R4: an accepted wide write adds two entries
    assert_pair_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pair && !drop && !rd) |=> cnt == $past(cnt) + CW'(2));
    // R10: popping an empty FIFO changes nothing
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cnt == '0 && !wr) |=> cnt == '0);
endmodule

// File: rtl/cdm_ctrl.sv
module cdm_ctrl
    import cdm_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CFG_W    = 7,
    parameter int CELL_DEF = 53,
    localparam int CHW     = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             soc,
    input  logic [CHW-1:0]   chan_sel,
    input  logic             bus_narrow,
    input  logic             cfg_ld,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             wr_go,
    output logic             wr_pair,
    output logic [CHW-1:0]   tgt_chan,
    output logic [CFG_W-1:0] thresh
);
    cdm_state_e     state_q, state_d;
    logic [CHW-1:0] chan_q;
    logic           start_w;

    assign start_w = !wr_n && soc;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_w) state_d = S_CELL;   // T_START
            S_CELL: state_d = S_CELL;                // T_RESTART / T_HOLD
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            chan_q  <= '0;
            thresh  <= CFG_W'(CELL_DEF);
        end else begin
            state_q <= state_d;
            if (start_w)               chan_q <= chan_sel;
            if (cfg_ld && bus_narrow)  thresh <= cfg_in;
        end
    end

    always_comb begin
        wr_pair  = !bus_narrow;
        tgt_chan = soc ? chan_sel : chan_q;
        unique case (state_q)
            S_IDLE:  wr_go = start_w;
            S_CELL:  wr_go = !wr_n;
            default: wr_go = 1'b0;
        endcase
    end

    // R5: latched channel only moves on a strobed start-of-cell word
    assert_chan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |=> $stable(chan_q));
    // R6: an open cell never falls back to idle
    assert_cell_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_CELL |=> state_q == S_CELL);
    // R8: cell length changes only on a narrow-mode load
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ld && bus_narrow) |=> $stable(thresh));
endmodule

// File: rtl/cell_demux_wr.sv
module cell_demux_wr #(
    parameter int NCH      = 4,
    parameter int DEPTH    = 128,
    parameter int W        = 9,
    parameter int CFG_W    = 7,
    parameter int CELL_DEF = 53,
    localparam int CHW     = $clog2(NCH),
    localparam int CW      = $clog2(DEPTH) + 1,
    localparam int DW      = 2 * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             soc,
    input  logic [CHW-1:0]   chan_sel,
    input  logic             bus_narrow,
    input  logic [DW-1:0]    din,
    input  logic             cfg_ld,
    output logic             space_ok,
    input  logic [NCH-1:0]   rd_en,
    output logic [NCH*W-1:0] rd_data,
    output logic [NCH-1:0]   fifo_empty,
    output logic [NCH-1:0]   ovf
);
    logic             wr_go, wr_pair;
    logic [CHW-1:0]   tgt_chan;
    logic [CFG_W-1:0] thresh;
    logic [CW-1:0]    cnt_a [NCH];
    logic [NCH-1:0]   drop_v;
    logic [CW-1:0]    free_sel;

    cdm_ctrl #(
        .NCH(NCH), .CFG_W(CFG_W), .CELL_DEF(CELL_DEF)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .soc(soc),
        .chan_sel(chan_sel), .bus_narrow(bus_narrow), .cfg_ld(cfg_ld),
        .cfg_in(din[DW-1 -: CFG_W]),
        .wr_go(wr_go), .wr_pair(wr_pair), .tgt_chan(tgt_chan), .thresh(thresh)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cdm_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_go && (tgt_chan == CHW'(i))),
            .pair(wr_pair),
            .d_lo(din[W-1:0]), .d_hi(din[DW-1:W]),
            .rd(rd_en[i]),
            .head(rd_data[i*W +: W]),
            .cnt(cnt_a[i]),
            .drop(drop_v[i])
        );

        assign fifo_empty[i] = (cnt_a[i] == '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ovf[i] <= 1'b0;
            else if (drop_v[i]) ovf[i] <= 1'b1;
        end

        // R9: overflow flag is sticky
        assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> ovf[i]);
    end

    always_comb begin
        free_sel = CW'(DEPTH) - cnt_a[chan_sel];
        space_ok = free_sel >= CW'(thresh);
    end

    // R7: a full selected FIFO can never report cell space
    assert_full_no_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a[chan_sel] == CW'(DEPTH) && thresh != '0) |-> !space_ok);
endmodule

// File: tb/cell_demux_wr_bench.sv
module cell_demux_wr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic        soc = 1'b0;
    logic [1:0]  chan_sel = '0;
    logic        bus_narrow = 1'b1;
    logic [17:0] din = '0;
    logic        cfg_ld = 1'b0;
    logic        space_ok;
    logic [3:0]  rd_en = '0;
    logic [35:0] rd_data;
    logic [3:0]  fifo_empty;
    logic [3:0]  ovf;

    int checks = 0;
    int errors = 0;

    logic [8:0] mq [4][$];
    logic       m_started;
    logic [1:0] m_chan;
    logic [3:0] m_ovf;

    // {soc, chan, narrow, din}
    localparam logic [21:0] VEC [8] = '{
        {1'b1, 2'd1, 1'b1, 18'h000A5},
        {1'b0, 2'd3, 1'b1, 18'h3C1F3},
        {1'b1, 2'd0, 1'b0, 18'h2B4C7},
        {1'b0, 2'd2, 1'b0, 18'h1F0E1},
        {1'b1, 2'd3, 1'b1, 18'h00111},
        {1'b1, 2'd2, 1'b0, 18'h3FFFF},
        {1'b0, 2'd0, 1'b1, 18'h00042},
        {1'b1, 2'd1, 1'b0, 18'h12345}
    };

    cell_demux_wr u_cell_demux_wr (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .soc(soc), .chan_sel(chan_sel),
        .bus_narrow(bus_narrow), .din(din), .cfg_ld(cfg_ld), .space_ok(space_ok),
        .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty), .ovf(ovf)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) mq[c].delete();
        m_started = 1'b0;
        m_chan = '0;
        m_ovf = '0;
    endtask

    task automatic wr_word(input logic s, input logic [1:0] ch, input logic nar, input logic [17:0] d);
        logic [1:0] c;
        int need;
        wr_n = 1'b0; soc = s; chan_sel = ch; bus_narrow = nar; din = d;
        if (s) begin m_started = 1'b1; m_chan = ch; end
        if (m_started) begin
            c = s ? ch : m_chan;
            need = nar ? 1 : 2;
            if (128 - mq[c].size() >= need) begin
                mq[c].push_back(d[8:0]);
                if (!nar) mq[c].push_back(d[17:9]);
            end else begin
                m_ovf[c] = 1'b1;
            end
        end
        @(negedge clk);
        wr_n = 1'b1; soc = 1'b0;
    endtask

    task automatic cfg_load(input logic nar, input logic [6:0] v);
        cfg_ld = 1'b1; bus_narrow = nar; din = {v, 11'h0};
        @(negedge clk);
        cfg_ld = 1'b0;
    endtask

    task automatic pop(input int ch, input string tag);
        logic [8:0] e;
        e = mq[ch].pop_front();
        check(tag, 36'(rd_data[ch*9 +: 9]), 36'(e));
        rd_en[ch] = 1'b1;
        @(negedge clk);
        rd_en[ch] = 1'b0;
    endtask

    task automatic drain(input int ch, input string tag);
        while (mq[ch].size() > 0) pop(ch, tag);
        check({tag, " empty"}, 36'(fifo_empty[ch]), 36'd1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 empty", 36'(fifo_empty), 36'hF);
        check("R1 ovf", 36'(ovf), 36'h0);
        for (int c = 0; c < 4; c++) begin
            chan_sel = 2'(c);
            #1 check("R1 space", 36'(space_ok), 36'd1);
        end
        @(negedge clk);

        // R6: word before any start-of-cell is discarded
        wr_word(1'b0, 2'd1, 1'b1, 18'h00077);
        check("R6 pre-soc dropped", 36'(fifo_empty), 36'hF);

        // R3 R4 R5: table of mixed writes
        for (int i = 0; i < 8; i++)
            wr_word(VEC[i][21], VEC[i][20:19], VEC[i][18], VEC[i][17:0]);
        for (int c = 0; c < 4; c++) drain(c, "R3 R4 R5 R10 data");

        // R2: strobe high stores nothing
        soc = 1'b1; chan_sel = 2'd0; din = 18'h0055; wr_n = 1'b1;
        @(negedge clk);
        soc = 1'b0;
        check("R2 no strobe", 36'(fifo_empty), 36'hF);

        // R7: cell space boundary on channel 2
        wr_word(1'b1, 2'd2, 1'b1, 18'h00100);
        for (int k = 1; k < 75; k++) wr_word(1'b0, 2'd2, 1'b1, 18'(k));
        chan_sel = 2'd2;
        #1 check("R7 free53", 36'(space_ok), 36'd1);
        wr_word(1'b0, 2'd2, 1'b1, 18'h00033);
        chan_sel = 2'd2;
        #1 check("R7 free52", 36'(space_ok), 36'd0);
        chan_sel = 2'd0;
        #1 check("R7 other chan", 36'(space_ok), 36'd1);
        chan_sel = 2'd2;
        @(negedge clk);

        // R8: wide-mode load ignored, narrow-mode load applied
        cfg_load(1'b0, 7'd10);
        check("R8 wide ignored", 36'(space_ok), 36'd0);
        cfg_load(1'b1, 7'd52);
        check("R8 narrow load", 36'(space_ok), 36'd1);

        // R9: fill to 127, wide write dropped whole
        for (int k = 0; k < 51; k++) wr_word(1'b0, 2'd2, 1'b1, 18'(9'h1C0 + k));
        check("R9 no ovf yet", 36'(ovf), 36'h0);
        wr_word(1'b0, 2'd2, 1'b0, 18'h2AAAA);
        check("R9 wide drop ovf", 36'(ovf), 36'(m_ovf));
        wr_word(1'b0, 2'd2, 1'b1, 18'h000EE);
        chan_sel = 2'd2;
        #1 check("R7 full", 36'(space_ok), 36'd0);
        @(negedge clk);
        wr_word(1'b0, 2'd2, 1'b1, 18'h000DD);
        drain(2, "R9 R10 contents");
        check("R9 sticky", 36'(ovf), 36'h4);

        // R1 R8: reset clears flags and restores cell length 53
        do_reset();
        check("R1 ovf cleared", 36'(ovf), 36'h0);
        wr_word(1'b1, 2'd0, 1'b1, 18'h0);
        for (int k = 1; k < 76; k++) wr_word(1'b0, 2'd0, 1'b1, 18'(k));
        chan_sel = 2'd0;
        #1 check("R8 reset length", 36'(space_ok), 36'd0);
        @(negedge clk);
        drain(0, "R10 drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule